// File: doc/BRIEF.md
# I2C Pin Recovery Multiplexer

This block sits between an I2C protocol engine and the two open-drain pads of its bus, the clock line and the data line. Normally the engine owns both pads. If a target device holds the data line low and the bus stalls, software sets one mode bit to take both lines away from the engine. It then toggles the clock line by hand until the bus frees. The recovery sequence itself, including the number of clock pulses, is left to software. The hardware only provides the pin-level access.

In pin mode each line has a direction bit and an output latch. The latch cannot be written directly. A write-one-to-set offset raises latch bits and a write-one-to-clear offset lowers them, so software can change one line without first reading the other. Both pads are open-drain: a pad is pulled low only when its line is an output and its latch is 0. Otherwise the line is released to the external pull-up. The level register shows the live pad levels in either mode, after a synchronizer.

The register port is a plain single-cycle write strobe with a combinational read of the addressed register. There is no data stream here, so no valid/ready handshake is used. Pin index 0 is the clock line (SCL) and index 1 is the data line (SDA) in every register.

Top module: `i2c_pin_recov`

## Requirements
- R1: During and after reset the block is in engine mode, both direction bits are 0, both latch bits are 1, both pad pull-downs are off, and the level register reads 2'b11 until the synchronizer has filled.
- R2: Bit 0 of the mode register at offset 0 selects pin mode when 1 and engine mode when 0, and reads back. In engine mode each pad pull-down equals the engine's pull-down request for that line.
- R3: In pin mode the engine's pull-down requests have no effect on the pads, and both engine sense outputs read 1 (a released bus).
- R4: In engine mode each engine sense output equals its raw pad input level, with no added delay.
- R5: The direction register at offset 1 holds bit 0 (SCL is an output) and bit 1 (SDA is an output), and reads back.
- R6: Writing 1 to bit 0 or bit 1 at offset 3 sets the SCL or SDA latch bit. Bits written as 0 leave the latch unchanged.
- R7: Writing 1 to bit 0 or bit 1 at offset 4 clears the SCL or SDA latch bit. Bits written as 0 leave the latch unchanged.
- R8: Offsets 3 and 4 always read as zero.
- R9: In pin mode a line whose direction bit is 0 is released, whatever its latch holds. A line whose direction bit is 1 is pulled low exactly when its latch bit is 0.
- R10: The level register at offset 2 returns the SCL pad level in bit 0 and the SDA pad level in bit 1. Each level appears two clock edges after the pad changes, in both modes. Writes to offset 2 are ignored.
- R11: The direction bits and the latch keep their values across mode changes, so a latch value set up in engine mode takes effect when pin mode is entered.
- R12: Offsets 5 to 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_addr | input | ADDR_W | Register offset for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data of the addressed register |
| eng_scl_oe | input | 1 | Engine asks to pull the clock line low |
| eng_sda_oe | input | 1 | Engine asks to pull the data line low |
| eng_scl_in | output | 1 | Clock line level as seen by the engine |
| eng_sda_in | output | 1 | Data line level as seen by the engine |
| pad_scl_in | input | 1 | Clock pad level |
| pad_sda_in | input | 1 | Data pad level |
| pad_scl_oe | output | 1 | Clock pad pull-down enable (1 pulls low) |
| pad_sda_oe | output | 1 | Data pad pull-down enable (1 pulls low) |

## Verification
The bound checker checks the following on every cycle:
- engine pass-through of both drive and sense while not in pin mode;
- that the pads stay still in pin mode between writes, whatever the engine requests;
- the release of input-direction lines;
- set and clear taking effect on the next cycle;
- zero reads at the set and clear offsets;
- the two-edge latency of the level register.

Only the bench's scenarios can show that latch and direction survive a round trip through engine mode. The same holds for writes of zero bits to set or clear being inert, writes to the level and unmapped offsets being dropped, and the reset values seen before any write.

// File: rtl/i2c_recov_pkg.sv
package i2c_recov_pkg;

  // Two bus lines; index order is fixed by the register layout.
  localparam int NPIN    = 2;
  localparam int PIN_SCL = 0;
  localparam int PIN_SDA = 1;

  // Register offsets.
  localparam int OFS_MODE  = 0;
  localparam int OFS_DIR   = 1;
  localparam int OFS_LEVEL = 2;
  localparam int OFS_SET   = 3;
  localparam int OFS_CLR   = 4;

  typedef logic [NPIN-1:0] pinvec_t;

  typedef enum logic [2:0] {
    SEL_MODE,
    SEL_DIR,
    SEL_LEVEL,
    SEL_SET,
    SEL_CLR,
    SEL_NONE
  } regsel_t;

endpackage

// File: rtl/i2c_recov_sync.sv
module i2c_recov_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // One independent flop chain per line.
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d[g]};
    end

    assign q[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2c_recov_regs.sv
module i2c_recov_regs
  import i2c_recov_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  pinvec_t           level,
  output logic              gpio_mode,
  output pinvec_t           dir,
  output pinvec_t           out_lvl,
  output logic [DATA_W-1:0] rdata
);

  regsel_t sel;
  pinvec_t wbits;
  logic    wr_mode, wr_dir, wr_set, wr_clr;
  logic    unused_wdata_hi;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_MODE))  sel = SEL_MODE;
    else if (addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_LEVEL)) sel = SEL_LEVEL;
    else if (addr == ADDR_W'(OFS_SET))   sel = SEL_SET;
    else if (addr == ADDR_W'(OFS_CLR))   sel = SEL_CLR;
  end

  assign wbits           = wdata[NPIN-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:NPIN];

  assign wr_mode = wr && (sel == SEL_MODE);
  assign wr_dir  = wr && (sel == SEL_DIR);
  assign wr_set  = wr && (sel == SEL_SET);
  assign wr_clr  = wr && (sel == SEL_CLR);

  // The latch resets to all ones, so both lines start released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_mode <= 1'b0;
      dir       <= '0;
      out_lvl   <= '1;
    end else begin
      if (wr_mode) gpio_mode <= wdata[0];
      if (wr_dir)  dir       <= wbits;
      if (wr_set)  out_lvl   <= out_lvl | wbits;
      else if (wr_clr) out_lvl <= out_lvl & ~wbits;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MODE:  rdata = DATA_W'(gpio_mode);
      SEL_DIR:   rdata = DATA_W'(dir);
      SEL_LEVEL: rdata = DATA_W'(level);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/i2c_recov_pinmux.sv
module i2c_recov_pinmux
  import i2c_recov_pkg::*;
(
  input  logic    gpio_mode,
  input  pinvec_t dir,
  input  pinvec_t out_lvl,
  input  pinvec_t eng_oe,
  input  pinvec_t pad_in,
  output pinvec_t pad_oe,
  output pinvec_t eng_in
);

  // Open drain: a line is pulled low or released, never driven high.
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign pad_oe[g] = gpio_mode ? (dir[g] & ~out_lvl[g]) : eng_oe[g];
    assign eng_in[g] = gpio_mode ? 1'b1 : pad_in[g];
  end

endmodule

// File: rtl/i2c_pin_recov.sv
module i2c_pin_recov
  import i2c_recov_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_scl_oe,
  input  logic              eng_sda_oe,
  output logic              eng_scl_in,
  output logic              eng_sda_in,
  input  logic              pad_scl_in,
  input  logic              pad_sda_in,
  output logic              pad_scl_oe,
  output logic              pad_sda_oe
);

  logic    gpio_mode;
  pinvec_t pin_dir, pin_out, pin_level;
  pinvec_t eng_oe_v, eng_in_v, pad_in_v, pad_oe_v;

  assign eng_oe_v[PIN_SCL] = eng_scl_oe;
  assign eng_oe_v[PIN_SDA] = eng_sda_oe;
  assign pad_in_v[PIN_SCL] = pad_scl_in;
  assign pad_in_v[PIN_SDA] = pad_sda_in;
  assign eng_scl_in        = eng_in_v[PIN_SCL];
  assign eng_sda_in        = eng_in_v[PIN_SDA];
  assign pad_scl_oe        = pad_oe_v[PIN_SCL];
  assign pad_sda_oe        = pad_oe_v[PIN_SDA];

  i2c_recov_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in_v),
    .q    (pin_level)
  );

  i2c_recov_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .level    (pin_level),
    .gpio_mode(gpio_mode),
    .dir      (pin_dir),
    .out_lvl  (pin_out),
    .rdata    (reg_rdata)
  );

  i2c_recov_pinmux u_mux (
    .gpio_mode(gpio_mode),
    .dir      (pin_dir),
    .out_lvl  (pin_out),
    .eng_oe   (eng_oe_v),
    .pad_in   (pad_in_v),
    .pad_oe   (pad_oe_v),
    .eng_in   (eng_in_v)
  );

endmodule

// File: rtl/i2c_pin_recov_chk.sv
module i2c_pin_recov_chk
  import i2c_recov_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              gpio_mode,
  input pinvec_t           pin_dir,
  input pinvec_t           eng_oe_v,
  input pinvec_t           eng_in_v,
  input pinvec_t           pad_in_v,
  input pinvec_t           pad_oe_v
);

  // Edges since reset, saturating; gates the two-edge level check.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_engine_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_mode |-> (pad_oe_v == eng_oe_v));

  assert_engine_sense_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_mode |-> (eng_in_v == pad_in_v));

  assert_engine_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_mode && $past(gpio_mode) && !$past(reg_wr)) |-> $stable(pad_oe_v));

  assert_set_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_mode && reg_wr && reg_addr == ADDR_W'(OFS_SET) && reg_wdata[PIN_SCL])
      |=> !pad_oe_v[PIN_SCL]);

  assert_clr_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_mode && pin_dir[PIN_SDA] && reg_wr && reg_addr == ADDR_W'(OFS_CLR)
      && reg_wdata[PIN_SDA]) |=> pad_oe_v[PIN_SDA]);

  assert_setclr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_SET) || reg_addr == ADDR_W'(OFS_CLR))
      |-> (reg_rdata == '0));

  assert_input_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_mode |-> ((pad_oe_v & ~pin_dir) == '0));

  assert_level_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && reg_addr == ADDR_W'(OFS_LEVEL))
      |-> (reg_rdata[NPIN-1:0] == $past(pad_in_v, 2)));

endmodule

bind i2c_pin_recov i2c_pin_recov_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .gpio_mode(gpio_mode),
  .pin_dir  (pin_dir),
  .eng_oe_v (eng_oe_v),
  .eng_in_v (eng_in_v),
  .pad_in_v (pad_in_v),
  .pad_oe_v (pad_oe_v)
);

// File: tb/i2c_pin_recov_test.sv
module i2c_pin_recov_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 16;
  localparam int N_RANDOM   = 3000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              eng_scl_oe = 1'b0, eng_sda_oe = 1'b0;
  logic              eng_scl_in, eng_sda_in;
  logic              pad_scl_in = 1'b1, pad_sda_in = 1'b1;
  logic              pad_scl_oe, pad_sda_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Requirement model state.
  bit       m_mode = 1'b0;
  bit [1:0] m_dir  = 2'b00;
  bit [1:0] m_out  = 2'b11;
  bit [1:0] m_s1   = 2'b11;
  bit [1:0] m_s2   = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_pin_recov #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe),
    .eng_scl_in(eng_scl_in), .eng_sda_in(eng_sda_in),
    .pad_scl_in(pad_scl_in), .pad_sda_in(pad_sda_in),
    .pad_scl_oe(pad_scl_oe), .pad_sda_oe(pad_sda_oe)
  );

  function automatic bit [1:0] exp_pad_oe(bit [1:0] eoe);
    return m_mode ? (m_dir & ~m_out) : eoe;
  endfunction

  function automatic bit [1:0] exp_eng_in(bit [1:0] pad);
    return m_mode ? 2'b11 : pad;
  endfunction

  function automatic bit [DATA_W-1:0] exp_rdata(int a);
    case (a)
      0:       return DATA_W'(m_mode);
      1:       return DATA_W'(m_dir);
      2:       return DATA_W'(m_s2);
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    case (a)
      0: return "R2";
      1: return "R5";
      2: return "R10";
      3, 4: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, check, then advance the model.
  task automatic cycle(bit wr, bit [ADDR_W-1:0] a, bit [DATA_W-1:0] d,
                       bit [1:0] eoe, bit [1:0] pad);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    eng_scl_oe = eoe[0]; eng_sda_oe = eoe[1];
    pad_scl_in = pad[0]; pad_sda_in = pad[1];
    #1;
    check(m_mode ? "R3/R9" : "R2", DATA_W'({pad_sda_oe, pad_scl_oe}),
          DATA_W'(exp_pad_oe(eoe)));
    check(m_mode ? "R3" : "R4", DATA_W'({eng_sda_in, eng_scl_in}),
          DATA_W'(exp_eng_in(pad)));
    check(rd_tag(int'(a)), reg_rdata, exp_rdata(int'(a)));
    @(posedge clk);
    if (wr) begin
      case (int'(a))
        0: m_mode = d[0];
        1: m_dir  = d[1:0];
        3: m_out  = m_out | d[1:0];
        4: m_out  = m_out & ~d[1:0];
        default: ;
      endcase
    end
    m_s2 = m_s1;
    m_s1 = pad;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    // R1: state held in reset.
    repeat (3) @(negedge clk);
    reg_addr = 3'd0; #1;
    check("R1", reg_rdata, '0);
    check("R1", DATA_W'({pad_sda_oe, pad_scl_oe}), '0);
    reg_addr = 3'd1; #1;
    check("R1", reg_rdata, '0);
    reg_addr = 3'd2; #1;
    check("R1", reg_rdata, DATA_W'(2'b11));
    @(negedge clk); rst_n = 1'b1;

    // R2, R4: engine owns the pads.
    cycle(0, 3'd0, 0, 2'b01, 2'b10);
    cycle(0, 3'd2, 0, 2'b10, 2'b01);
    // R11: clear SCL latch while in engine mode, pads unaffected.
    cycle(1, 3'd4, 16'h0001, 2'b00, 2'b11);
    cycle(1, 3'd1, 16'h0001, 2'b00, 2'b11);
    cycle(1, 3'd0, 16'h0001, 2'b11, 2'b11);
    #1;
    check("R11", DATA_W'(pad_scl_oe), 1);
    check("R9", DATA_W'(pad_sda_oe), 0);
    // R3: engine requests ignored in pin mode.
    cycle(0, 3'd0, 0, 2'b11, 2'b00);
    // R6: zero bits inert, then set releases SCL.
    cycle(1, 3'd3, 16'hFFFC, 2'b00, 2'b11);
    #1; check("R6", DATA_W'(pad_scl_oe), 1);
    cycle(1, 3'd3, 16'h0001, 2'b00, 2'b11);
    #1; check("R6", DATA_W'(pad_scl_oe), 0);
    // R7: zero bits inert, then clear pulls SCL low.
    cycle(1, 3'd4, 16'h0000, 2'b00, 2'b11);
    #1; check("R7", DATA_W'(pad_scl_oe), 0);
    cycle(1, 3'd4, 16'h0003, 2'b00, 2'b11);
    #1; check("R7", DATA_W'(pad_scl_oe), 1);
    // R9: SDA latch low but SDA is an input, so it stays released.
    check("R9", DATA_W'(pad_sda_oe), 0);
    // R10: writes to level dropped; R12: unmapped writes dropped.
    cycle(1, 3'd2, 16'h0000, 2'b00, 2'b10);
    cycle(1, 3'd6, 16'hFFFF, 2'b00, 2'b10);
    cycle(0, 3'd2, 0, 2'b00, 2'b10);
    cycle(0, 3'd1, 0, 2'b00, 2'b10);
    // R11: back to engine mode and again to pin mode, latch kept.
    cycle(1, 3'd0, 16'h0000, 2'b00, 2'b11);
    cycle(1, 3'd0, 16'h0001, 2'b00, 2'b11);
    #1; check("R11", DATA_W'(pad_scl_oe), 1);

    // Random mix against the requirement model.
    for (int i = 0; i < N_RANDOM; i++) begin
      bit              w;
      bit [ADDR_W-1:0] a;
      a = ADDR_W'($urandom % 8);
      w = ($urandom % 2) == 0;
      cycle(w, a, DATA_W'($urandom), 2'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule